// File: doc/BRIEF.md
# Pulse-Counting Carrier Detector

This block decides whether a frequency-shift-keyed line signal is present with enough amplitude to be trusted. An external threshold comparator sits in front of it. That comparator stays low while the line is quiet and produces one pulse per cycle of any tone that exceeds its threshold. The block counts those pulses on a 460.8 kHz clock. It raises a carrier flag only after an unbroken run of pulses, and keeps the flag up while pulses keep arriving within a timeout window.

The flag is forced off whenever the local station is transmitting. The flag gates the receive data path of a half-duplex modem, so a noise burst must not unlock the receiver, and a tone that stops must close the receiver quickly. The run length is `PULSES_NEEDED`, with a default of 4. The window is `CLK_GAP` clocks, with a default of 1152, which is 2.5 ms at 460.8 kHz. The time to assert therefore depends on the tone: about 3.3 ms at 1200 Hz and about 1.8 ms at 2200 Hz.

Top module: `carrier_detect`

## Requirements
- R1: While `rst` is high, and at the first clock after it is released, `carrier_o` is 0.
- R2: With `tx_req_n` at 1, `carrier_o` rises 2 clocks after the sampling edge at which `cmp_in` is first seen high for the PULSES_NEEDED-th rise of a run. Fewer rises leave it at 0.
- R3: Once `carrier_o` is high, it stays high while `tx_req_n` is 1 and each `cmp_in` rise follows the previous counted rise by fewer than CLK_GAP clocks.
- R4: If CLK_GAP clocks pass after a counted rise with no further rise, `carrier_o` drops at that clock and the run count returns to zero.
- R5: After any drop, a full fresh run of PULSES_NEEDED rises is needed before `carrier_o` rises again. A rise that arrives CLK_GAP or more clocks after the previous one counts as the first of a new run.
- R6: `tx_req_n` = 0 means the station is transmitting. In that state `carrier_o` is 0 in the same cycle, the run count is cleared, and rises seen while it is 0 are not counted.
- R7: Only a 0-to-1 transition of `cmp_in` counts. Holding `cmp_in` at 1 adds nothing more to the run.
- R8: Rises beyond PULSES_NEEDED keep `carrier_o` high. The run count saturates and never wraps back to a low value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 460.8 kHz sample clock |
| rst | input | 1 | Synchronous reset, active high |
| cmp_in | input | 1 | Asynchronous pulse train from the amplitude comparator |
| tx_req_n | input | 1 | Request to send, active low; 0 forces the flag off |
| carrier_o | output | 1 | Carrier present flag |

## Verification
The bench builds the detector with CLK_GAP = 48 and PULSES_NEEDED = 4. This keeps the timeout to a few dozen clocks, so a single run can cover many expiries, restarts after a drop, and rises landing one clock either side of the window edge. Random pulse spacing from 6 to 70 clocks straddles the 48-clock limit. The stimulus also includes short transmit bursts, so saturation, the transmit override and fresh-run counting are all reached repeatedly. The bench compares the flag every clock against a timestamp-based model of the requirements.

// File: rtl/cdet_pkg.sv
package cdet_pkg;

    // Per-cycle events that steer the run counter.
    typedef struct packed {
        logic rise;     // synchronized comparator rising edge
        logic expired;  // gap window has run out
        logic tx_hold;  // station is transmitting
    } cdet_evt_t;

    // Width needed to hold values 0 .. n-1, never less than one bit.
    function automatic int unsigned bits_for(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/cdet_edge.sv
module cdet_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    localparam int unsigned NS = (STAGES < 1) ? 1 : STAGES;

    logic [NS-1:0] sync_q;
    logic          last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            for (int i = NS - 1; i > 0; i--) begin
                sync_q[i] <= sync_q[i-1];
            end
            sync_q[0] <= din;
            last_q    <= sync_q[NS-1];
        end
    end

    assign rise = sync_q[NS-1] & ~last_q;

endmodule

// File: rtl/cdet_gap_timer.sv
module cdet_gap_timer #(
    parameter int unsigned LIMIT = 1152
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic expired
);
    localparam int unsigned GW  = cdet_pkg::bits_for(LIMIT);
    localparam logic [GW-1:0] TOP = GW'(LIMIT - 1);

    logic [GW-1:0] age_q;

    // Reset parks the timer in the expired state: no run is open.
    always_ff @(posedge clk) begin
        if (rst) begin
            age_q <= TOP;
        end else if (restart) begin
            age_q <= '0;
        end else if (age_q != TOP) begin
            age_q <= age_q + 1'b1;
        end
    end

    assign expired = (age_q == TOP);

endmodule

// File: rtl/cdet_run_counter.sv
module cdet_run_counter
    import cdet_pkg::*;
#(
    parameter int unsigned TARGET = 4,
    parameter int unsigned CW     = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  cdet_evt_t     evt,
    output logic [CW-1:0] count,
    output logic          full
);
    localparam logic [CW-1:0] GOAL = CW'(TARGET);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (evt.tx_hold) begin
            cnt_q <= '0;
        end else if (evt.rise) begin
            // A rise after an expired window opens a new run.
            if (evt.expired)      cnt_q <= CW'(1);
            else if (cnt_q < GOAL) cnt_q <= cnt_q + 1'b1;
        end else if (evt.expired) begin
            cnt_q <= '0;
        end
    end

    assign count = cnt_q;
    assign full  = (cnt_q == GOAL);

endmodule

// File: rtl/carrier_detect.sv
module carrier_detect
    import cdet_pkg::*;
#(
    parameter int unsigned CLK_GAP       = 1152,
    parameter int unsigned PULSES_NEEDED = 4,
    parameter int unsigned SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cmp_in,
    input  logic tx_req_n,
    output logic carrier_o
);
    localparam int unsigned CNT_W = bits_for(PULSES_NEEDED + 1);

    logic             rise_pulse;
    logic             gap_expired;
    logic             run_full;
    logic [CNT_W-1:0] pulse_cnt;
    cdet_evt_t        evt;

    cdet_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .din  (cmp_in),
        .rise (rise_pulse)
    );

    cdet_gap_timer #(.LIMIT(CLK_GAP)) u_gap (
        .clk     (clk),
        .rst     (rst),
        .restart (rise_pulse),
        .expired (gap_expired)
    );

    assign evt.rise    = rise_pulse;
    assign evt.expired = gap_expired;
    assign evt.tx_hold = ~tx_req_n;

    cdet_run_counter #(.TARGET(PULSES_NEEDED), .CW(CNT_W)) u_run (
        .clk   (clk),
        .rst   (rst),
        .evt   (evt),
        .count (pulse_cnt),
        .full  (run_full)
    );

    // Transmit request overrides the flag in the same cycle.
    assign carrier_o = run_full & tx_req_n;

endmodule

// File: rtl/carrier_detect_chk.sv
module carrier_detect_chk #(
    parameter int unsigned CLK_GAP       = 1152,
    parameter int unsigned PULSES_NEEDED = 4,
    parameter int unsigned CW            = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          tx_req_n,
    input logic          carrier_o,
    input logic          rise_pulse,
    input logic          gap_expired,
    input logic [CW-1:0] pulse_cnt
);
    localparam int unsigned SW = $clog2(CLK_GAP + 2);

    // Independent count of clocks since the last synchronized rise.
    logic [SW-1:0] since_q;
    always_ff @(posedge clk) begin
        if (rst)                       since_q <= SW'(CLK_GAP);
        else if (rise_pulse)           since_q <= '0;
        else if (since_q < SW'(CLK_GAP)) since_q <= since_q + 1'b1;
    end

    AST_RISE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
        $rose(carrier_o) |-> ($past(rise_pulse) && tx_req_n)); // R2

    AST_DROP_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $fell(carrier_o) |-> (!tx_req_n || $past(gap_expired))); // R3

    AST_GAP_BOUND: assert property (@(posedge clk) disable iff (rst)
        carrier_o |-> (since_q < SW'(CLK_GAP))); // R4

    AST_TX_CLEARS_RUN: assert property (@(posedge clk) disable iff (rst)
        (tx_req_n && $past(!tx_req_n)) |-> !carrier_o); // R6

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        pulse_cnt <= CW'(PULSES_NEEDED)); // R8

endmodule

bind carrier_detect carrier_detect_chk #(
    .CLK_GAP       (CLK_GAP),
    .PULSES_NEEDED (PULSES_NEEDED),
    .CW            (CNT_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .tx_req_n    (tx_req_n),
    .carrier_o   (carrier_o),
    .rise_pulse  (rise_pulse),
    .gap_expired (gap_expired),
    .pulse_cnt   (pulse_cnt)
);

// File: tb/tb_carrier_detect.sv
`timescale 1ns/1ps
module tb_carrier_detect;
    localparam int unsigned GAP  = 48;
    localparam int unsigned NEED = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmp_in = 1'b0;
    logic tx_req_n = 1'b1;
    logic carrier_o;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    string tag = "R1";

    carrier_detect #(.CLK_GAP(GAP), .PULSES_NEEDED(NEED), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst(rst), .cmp_in(cmp_in), .tx_req_n(tx_req_n), .carrier_o(carrier_o)
    );

    always #4 clk = ~clk;

    // Reference model built from the requirements, in timestamps.
    longint cyc = 0;
    longint last_ev = -1000000;
    int run = 0;
    bit prev_s = 1'b0;
    bit [1:0] pipe = 2'b00;

    function automatic int next_run(input int r, input bit ev, input bit tx_on, input bit exp_w);
        if (tx_on)      return 0;
        if (ev)         return exp_w ? 1 : ((r < NEED) ? r + 1 : r);
        if (exp_w)      return 0;
        return r;
    endfunction

    always @(posedge clk) begin
        bit ev;
        bit expw;
        bit expct;
        cyc++;
        if (rst) begin
            run = 0; last_ev = -1000000; prev_s = 1'b0; pipe = 2'b00;
        end else begin
            ev = pipe[1];
            pipe = {pipe[0], (cmp_in && !prev_s)};
            prev_s = cmp_in;
            expw = ((cyc - last_ev) >= GAP);
            run = next_run(run, ev, !tx_req_n, expw);
            if (ev) last_ev = cyc;
        end
        #2;
        expct = !rst && (run == NEED) && tx_req_n;
        checks++;
        if (carrier_o !== expct) begin
            fails++;
            $display("FAIL %s: carrier_o=%0b expected %0b at cycle %0d", tag, carrier_o, expct, cyc);
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #4;
    endtask

    task automatic pulse(input int hi, input int lo);
        cmp_in = 1'b1; step(hi);
        cmp_in = 1'b0; step(lo);
    endtask

    initial begin
        void'($urandom(32'd20250601));
        step(5);
        tag = "R1"; rst = 1'b0; step(3);

        tag = "R2";                            // four rises, 20-clock spacing
        repeat (NEED) pulse(6, 14);
        step(4);

        tag = "R8";                            // extra rises saturate
        repeat (6) pulse(5, 35);

        tag = "R3";                            // spacing of GAP-1 still holds
        repeat (3) pulse(3, GAP - 4);

        tag = "R4";                            // silence expires the window
        step(GAP + 20);

        tag = "R5";                            // spacing of exactly GAP restarts runs
        repeat (6) pulse(3, GAP - 3);
        repeat (2) pulse(4, 10);
        step(GAP + 5);
        repeat (NEED) pulse(4, 12);
        step(10);

        tag = "R6";                            // transmit forces off, rises ignored
        tx_req_n = 1'b0; step(2);
        repeat (3) pulse(4, 8);
        tx_req_n = 1'b1; step(4);
        repeat (2) pulse(4, 8);
        repeat (NEED) pulse(4, 8);
        tx_req_n = 1'b0; step(1); tx_req_n = 1'b1; step(3);
        step(GAP + 5);

        tag = "R7";                            // level held high counts once
        cmp_in = 1'b1; step(3 * GAP);
        cmp_in = 1'b0; step(GAP + 5);
        cmp_in = 1'b1; step(10); cmp_in = 1'b0; step(10);
        repeat (2) pulse(GAP / 2, 5);
        step(GAP + 5);

        tag = "R3";                            // random spacing across the window edge
        for (int k = 0; k < 400; k++) begin
            int hi;
            int gap;
            hi  = $urandom_range(1, 5);
            gap = $urandom_range(6, 70);
            if ($urandom_range(0, 19) == 0) begin
                tx_req_n = 1'b0; step($urandom_range(1, 12)); tx_req_n = 1'b1;
            end
            pulse(hi, (gap > hi) ? gap - hi : 1);
        end
        step(GAP + 10);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule